// File: doc/BRIEF.md
# Indexed Event Pending and Enable Bank

This block keeps a pending flag and an enable flag for each of a parameterised number of level-sensitive system event inputs. The count is either 64 or 160, grouped into 32-event words. Any input held high raises its pending flag. The block drives a vector of interrupt requests, one per event. A request is high only when its event is pending and enabled, and the single global enable is on. Channel mapping and prioritisation happen downstream.

Software reaches every flag in two ways. In the first, it writes an event number to one of four index registers, which set or clear that one event's pending or enable flag. In the second, it writes a bitmask to a word register that covers 32 events. The word registers give write-one-to-clear on pending flags and separate write-one-to-set and write-one-to-clear on enable flags. Reads are combinational from the stored state. Per-word polarity and type registers read back as fixed constants for active-high, level-sensitive inputs.

Top module: `evt_pend_bank`

## Requirements
- R1: After reset every pending flag, every enable flag and the global enable are 0, and `irq_out` is all zero.
- R2: A write of event number n to address 0x01 sets pending flag n, and the new state is visible on the cycle after the write strobe. A value of NUM_EVENTS or more written there changes nothing.
- R3: A write of event number n to address 0x02 clears pending flag n, provided input n is low at that edge.
- R4: A write of n to address 0x03 sets enable flag n. A write of n to address 0x04 clears it. Out-of-range values are ignored.
- R5: A read of address 0x20+w returns pending word w, where event n sits in word n/32 at bit n%32. A read of 0x40+w returns the same word.
- R6: A write to address 0x40+w clears each pending flag of word w whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R7: A write to 0x60+w sets, and a write to 0x80+w clears, the enable flags of word w at the 1 bits of the data. A read at either address returns enable word w.
- R8: An input that is high at a clock edge sets its pending flag at that edge. The flag stays set after the input falls, until software clears it.
- R9: When a software clear and a high input reach the same pending flag in the same cycle, the flag remains set.
- R10: Bit 0 of address 0x00 is the global enable, and the address reads it back. `irq_out[n]` is 1 exactly when pending n, enable n and the global enable are all 1.
- R11: Reads of 0xA0+w return all ones and reads of 0xC0+w return all zeros. Writes to those addresses have no effect.
- R12: Reads of the index registers 0x01 to 0x04, of word addresses beyond the last word and of unassigned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_EVENTS | Active-high level event inputs |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Word address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | NUM_EVENTS | Pending, enabled and globally enabled events |

## Verification
A register write is taken at the rising edge where the strobe is high. Its result, whether a read value or a change in `irq_out`, is due immediately after that edge. An input level that is high at an edge shows in the pending word right after the same edge. The bench drives every stimulus on the falling edge and samples one nanosecond after the following falling edge, so exactly one rising edge lies between stimulus and check. Read data has no register stage, so each read is sampled in the cycle its address is applied.

// File: rtl/evtbank_pkg.sv
package evtbank_pkg;

   localparam int ADDR_W = 8;
   localparam int WORD_W = 32;

   // single-event index registers
   localparam logic [ADDR_W-1:0] A_GLOBAL   = 8'h00;
   localparam logic [ADDR_W-1:0] A_IDX_PSET = 8'h01;
   localparam logic [ADDR_W-1:0] A_IDX_PCLR = 8'h02;
   localparam logic [ADDR_W-1:0] A_IDX_ESET = 8'h03;
   localparam logic [ADDR_W-1:0] A_IDX_ECLR = 8'h04;

   // word regions occupy addr[7:5]; addr[4:0] selects the word
   typedef enum logic [2:0] {
      RG_NONE = 3'd0,
      RG_RAW  = 3'd1,
      RG_PCLR = 3'd2,
      RG_ESET = 3'd3,
      RG_ECLR = 3'd4,
      RG_POL  = 3'd5,
      RG_TYPE = 3'd6,
      RG_RSV  = 3'd7
   } region_e;

   typedef struct packed {
      logic [WORD_W-1:0] pset;
      logic [WORD_W-1:0] pclr;
      logic [WORD_W-1:0] eset;
      logic [WORD_W-1:0] eclr;
   } word_cmd_t;

   function automatic region_e region_of(input logic [ADDR_W-1:0] a);
      region_e r;
      case (a[7:5])
         3'd1:    r = RG_RAW;
         3'd2:    r = RG_PCLR;
         3'd3:    r = RG_ESET;
         3'd4:    r = RG_ECLR;
         3'd5:    r = RG_POL;
         3'd6:    r = RG_TYPE;
         3'd7:    r = RG_RSV;
         default: r = RG_NONE;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/evtbank_wr_decode.sv
module evtbank_wr_decode
   import evtbank_pkg::*;
#(
   parameter int NUM_EVENTS = 160,
   parameter int NUM_WORDS  = NUM_EVENTS / WORD_W
) (
   input  logic                               we,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [WORD_W-1:0]                  wdata,
   output word_cmd_t [NUM_WORDS-1:0]          cmd,
   output logic                               glb_we,
   output logic                               glb_d
);

   localparam int IDX_W = $clog2(NUM_EVENTS);

   logic             idx_ok;
   logic [IDX_W-1:0] idx;
   logic [WORD_W-1:0] idx_onehot;
   region_e          rg;

   assign idx_ok     = wdata < WORD_W'(NUM_EVENTS);
   assign idx        = wdata[IDX_W-1:0];
   assign idx_onehot = WORD_W'(1) << idx[4:0];
   assign rg         = region_of(addr);

   assign glb_we = we && (addr == A_GLOBAL);
   assign glb_d  = wdata[0];

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic      in_word;
      logic      at_word;
      word_cmd_t c;

      assign in_word = idx_ok && ((WORD_W'(idx) >> 5) == WORD_W'(w));
      assign at_word = (addr[4:0] == 5'(w));

      always_comb begin
         c = '0;
         if (we) begin
            if (addr == A_IDX_PSET && in_word) c.pset = idx_onehot;
            if (addr == A_IDX_PCLR && in_word) c.pclr = idx_onehot;
            if (addr == A_IDX_ESET && in_word) c.eset = idx_onehot;
            if (addr == A_IDX_ECLR && in_word) c.eclr = idx_onehot;
            if (at_word && rg == RG_PCLR)      c.pclr = wdata;
            if (at_word && rg == RG_ESET)      c.eset = wdata;
            if (at_word && rg == RG_ECLR)      c.eclr = wdata;
         end
      end

      assign cmd[w] = c;
   end

endmodule

// File: rtl/evtbank_word.sv
module evtbank_word
   import evtbank_pkg::*;
#(
   parameter int VALID_BITS = WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] evt_lvl,
   input  word_cmd_t         cmd,
   output logic [WORD_W-1:0] pend_q,
   output logic [WORD_W-1:0] en_q
);

   logic [WORD_W-1:0] pend_d;
   logic [WORD_W-1:0] en_d;
   logic [WORD_W-1:0] pend_raw;
   logic [WORD_W-1:0] en_raw;

   // sets (software or input level) win over clears
   assign pend_raw = (pend_q & ~cmd.pclr) | cmd.pset | evt_lvl;
   assign en_raw   = (en_q & ~cmd.eclr) | cmd.eset;

   if (VALID_BITS >= WORD_W) begin : g_full
      assign pend_d = pend_raw;
      assign en_d   = en_raw;
   end else begin : g_part
      localparam logic [WORD_W-1:0] KEEP = (WORD_W'(1) << VALID_BITS) - WORD_W'(1);
      assign pend_d = pend_raw & KEEP;
      assign en_d   = en_raw & KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         en_q   <= '0;
      end else begin
         pend_q <= pend_d;
         en_q   <= en_d;
      end
   end

endmodule

// File: rtl/evtbank_rd_mux.sv
module evtbank_rd_mux
   import evtbank_pkg::*;
#(
   parameter int NUM_WORDS = 5
) (
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [NUM_WORDS-1:0][WORD_W-1:0]  pend_words,
   input  logic [NUM_WORDS-1:0][WORD_W-1:0]  en_words,
   input  logic                              glb,
   output logic [WORD_W-1:0]                 rdata
);

   logic [WORD_W-1:0] pend_sel;
   logic [WORD_W-1:0] en_sel;
   logic              hit;

   always_comb begin
      pend_sel = '0;
      en_sel   = '0;
      hit      = 1'b0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (addr[4:0] == 5'(w)) begin
            pend_sel = pend_words[w];
            en_sel   = en_words[w];
            hit      = 1'b1;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_GLOBAL) begin
         rdata = {{(WORD_W-1){1'b0}}, glb};
      end else if (hit) begin
         case (region_of(addr))
            RG_RAW, RG_PCLR: rdata = pend_sel;
            RG_ESET, RG_ECLR: rdata = en_sel;
            RG_POL:          rdata = '1;
            default:         rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/evt_pend_bank.sv
module evt_pend_bank
   import evtbank_pkg::*;
#(
   parameter int NUM_EVENTS = 160
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_EVENTS-1:0] evt_in,
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [WORD_W-1:0]     bus_wdata,
   output logic [WORD_W-1:0]     bus_rdata,
   output logic [NUM_EVENTS-1:0] irq_out
);

   localparam int NUM_WORDS = (NUM_EVENTS + WORD_W - 1) / WORD_W;

   if (!(NUM_EVENTS == 64 || NUM_EVENTS == 160)) begin : g_bad_count
      $error("evt_pend_bank: NUM_EVENTS must be 64 or 160");
   end

   word_cmd_t [NUM_WORDS-1:0]          cmd;
   logic                               glb_we;
   logic                               glb_d;
   logic                               glb_q;
   logic [NUM_WORDS-1:0][WORD_W-1:0]   pend_words;
   logic [NUM_WORDS-1:0][WORD_W-1:0]   en_words;
   logic [NUM_EVENTS-1:0]              pend_all;
   logic [NUM_EVENTS-1:0]              en_all;

   evtbank_wr_decode #(
      .NUM_EVENTS (NUM_EVENTS),
      .NUM_WORDS  (NUM_WORDS)
   ) u_dec (
      .we     (bus_we),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .cmd    (cmd),
      .glb_we (glb_we),
      .glb_d  (glb_d)
   );

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_bank
      localparam int BITS = (NUM_EVENTS - w * WORD_W >= WORD_W) ? WORD_W
                                                               : NUM_EVENTS - w * WORD_W;
      evtbank_word #(
         .VALID_BITS (BITS)
      ) u_word (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt_lvl (evt_in[w*WORD_W +: WORD_W]),
         .cmd     (cmd[w]),
         .pend_q  (pend_words[w]),
         .en_q    (en_words[w])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      glb_q <= 1'b0;
      else if (glb_we) glb_q <= glb_d;
   end

   assign pend_all = pend_words;
   assign en_all   = en_words;
   assign irq_out  = pend_all & en_all & {NUM_EVENTS{glb_q}};

   evtbank_rd_mux #(
      .NUM_WORDS (NUM_WORDS)
   ) u_rd (
      .addr       (bus_addr),
      .pend_words (pend_words),
      .en_words   (en_words),
      .glb        (glb_q),
      .rdata      (bus_rdata)
   );

endmodule

// File: rtl/evtbank_chk.sv
module evtbank_chk
   import evtbank_pkg::*;
#(
   parameter int NUM_EVENTS = 160
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_EVENTS-1:0] evt_in,
   input logic                  bus_we,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [WORD_W-1:0]     bus_wdata,
   input logic [NUM_EVENTS-1:0] irq_out,
   input logic [NUM_EVENTS-1:0] pend_all,
   input logic [NUM_EVENTS-1:0] en_all,
   input logic                  glb_q
);

   localparam int IW = $clog2(NUM_EVENTS);

   logic [IW-1:0] widx;
   logic          wvalid;

   assign widx   = bus_wdata[IW-1:0];
   assign wvalid = bus_wdata < WORD_W'(NUM_EVENTS);

   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_out == '0));

   a_r2_idx_set: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_IDX_PSET && wvalid) |=> pend_all[$past(widx)]);

   a_r3_idx_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_IDX_PCLR && wvalid && !evt_in[widx])
      |=> !pend_all[$past(widx)]);

   a_r4_en_set: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_IDX_ESET && wvalid) |=> en_all[$past(widx)]);

   a_r4_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_IDX_ECLR && wvalid) |=> !en_all[$past(widx)]);

   a_r8_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_all & $past(evt_in)) == $past(evt_in)));

   a_r10_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_q |-> (irq_out == '0));

   a_r10_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~(pend_all & en_all)) == '0);

endmodule

bind evt_pend_bank evtbank_chk #(
   .NUM_EVENTS (NUM_EVENTS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_in    (evt_in),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_out   (irq_out),
   .pend_all  (pend_all),
   .en_all    (en_all),
   .glb_q     (glb_q)
);

// File: tb/test_evt_pend_bank.sv
module test_evt_pend_bank;

   localparam int N = 160;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  evt_in = '0;
   logic          bus_we = 1'b0;
   logic [7:0]    bus_addr = 8'hFF;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   evt_pend_bank #(.NUM_EVENTS(N)) i_evt_pend_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_in    (evt_in),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chkirq(input string tag, input logic [N-1:0] exp);
      checks++;
      if (irq_out !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, irq_out, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 8'hFF; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chkirq("R1 irq after reset", '0);
      for (int w = 0; w < 5; w++) begin
         rd(8'h20 + 8'(w), d); chk32("R1 pending word zero", d, 32'h0);
         rd(8'h60 + 8'(w), d); chk32("R1 enable word zero", d, 32'h0);
      end
      rd(8'h00, d); chk32("R1 global zero", d, 32'h0);
   endtask

   task automatic t_index_pending;
      logic [31:0] d;
      wr(8'h01, 32'd37);
      rd(8'h21, d); chk32("R2 index set event 37", d, 32'h20);
      rd(8'h41, d); chk32("R5 alias read of word 1", d, 32'h20);
      wr(8'h01, 32'd160);
      for (int w = 0; w < 5; w++) begin
         rd(8'h20 + 8'(w), d);
         chk32("R2 out-of-range index ignored", d, (w == 1) ? 32'h20 : 32'h0);
      end
      wr(8'h01, 32'd159);
      rd(8'h24, d); chk32("R5 last event at word 4 bit 31", d, 32'h8000_0000);
      wr(8'h02, 32'd159);
      wr(8'h02, 32'd37);
      rd(8'h21, d); chk32("R3 index clear event 37", d, 32'h0);
      rd(8'h24, d); chk32("R3 index clear event 159", d, 32'h0);
   endtask

   task automatic t_word_clear;
      logic [31:0] d;
      wr(8'h01, 32'd3);
      wr(8'h01, 32'd70);
      wr(8'h40, 32'h0);
      rd(8'h20, d); chk32("R6 zero mask keeps word 0", d, 32'h8);
      wr(8'h40, 32'h8);
      rd(8'h20, d); chk32("R6 one bit clears event 3", d, 32'h0);
      rd(8'h22, d); chk32("R6 other word untouched", d, 32'h40);
   endtask

   task automatic t_enable;
      logic [31:0] d;
      wr(8'h03, 32'd70);
      rd(8'h62, d); chk32("R4 index enable event 70", d, 32'h40);
      wr(8'h60, 32'hF0);
      rd(8'h80, d); chk32("R7 word enable set", d, 32'hF0);
      wr(8'h80, 32'h30);
      rd(8'h60, d); chk32("R7 word enable clear", d, 32'hC0);
      wr(8'h04, 32'd200);
      rd(8'h62, d); chk32("R4 out-of-range disable ignored", d, 32'h40);
      wr(8'h04, 32'd70);
      rd(8'h82, d); chk32("R4 index disable event 70", d, 32'h0);
   endtask

   task automatic t_gate;
      logic [31:0] d;
      logic [N-1:0] e;
      e = '0; e[70] = 1'b1;
      wr(8'h03, 32'd70);
      #1 chkirq("R10 global off blocks", '0);
      wr(8'h00, 32'h1);
      #1 chkirq("R10 pending enabled global on", e);
      rd(8'h00, d); chk32("R10 global readback", d, 32'h1);
      wr(8'h04, 32'd70);
      #1 chkirq("R10 disabled event quiet", '0);
      wr(8'h03, 32'd70);
      wr(8'h42, 32'h40);
      #1 chkirq("R10 cleared event quiet", '0);
   endtask

   task automatic t_level;
      logic [31:0] d;
      logic [N-1:0] e;
      @(negedge clk); evt_in[100] = 1'b1;
      rd(8'h23, d); chk32("R8 input sets pending", d, 32'h10);
      wr(8'h02, 32'd100);
      rd(8'h23, d); chk32("R9 input wins over index clear", d, 32'h10);
      wr(8'h43, 32'h10);
      rd(8'h23, d); chk32("R9 input wins over word clear", d, 32'h10);
      @(negedge clk); evt_in[100] = 1'b0;
      rd(8'h23, d); chk32("R8 pending held after input low", d, 32'h10);
      wr(8'h02, 32'd100);
      rd(8'h23, d); chk32("R3 clear after input low", d, 32'h0);
      // level on enabled event 70 reaches irq_out
      @(negedge clk); evt_in[70] = 1'b1;
      @(negedge clk); evt_in[70] = 1'b0;
      e = '0; e[70] = 1'b1;
      #1 chkirq("R8 level event drives irq", e);
      wr(8'h02, 32'd70);
      #1 chkirq("R3 irq drops after clear", '0);
   endtask

   task automatic t_fixed_regs;
      logic [31:0] d;
      wr(8'hA0, 32'h0);
      wr(8'hC1, 32'hFFFF_FFFF);
      for (int w = 0; w < 5; w++) begin
         rd(8'hA0 + 8'(w), d); chk32("R11 polarity reads ones", d, 32'hFFFF_FFFF);
         rd(8'hC0 + 8'(w), d); chk32("R11 type reads zeros", d, 32'h0);
      end
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      wr(8'h05, 32'hFFFF_FFFF);
      rd(8'h20, d); chk32("R12 stray write no effect", d, 32'h0);
      rd(8'h01, d); chk32("R12 index register reads zero", d, 32'h0);
      rd(8'h04, d); chk32("R12 index register reads zero", d, 32'h0);
      rd(8'h25, d); chk32("R12 word beyond last reads zero", d, 32'h0);
      rd(8'hE0, d); chk32("R12 reserved region reads zero", d, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_index_pending();
      t_word_clear();
      t_enable();
      t_gate();
      t_level();
      t_fixed_regs();
      t_unmapped();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule